// File: doc/BRIEF.md
# Pulse-Distance Infrared Code Decoder

This block recovers a 32-bit remote-control word from the demodulated output of an infrared receiver module. The receiver line is active low: it sits high when no carrier is seen and drops low for as long as a carrier burst lasts. The decoder first waits for a long continuous burst that marks the start of a frame. It then treats the end of every burst, which is a rising edge on the line, as a bit strobe. At each strobe it looks at the carrier-off interval that came before the burst that just ended. A long interval gives a 1 and a short one gives a 0.

All timing is counted in microsecond ticks taken from a divider on the system clock, so the thresholds are independent of the clock rate. A frame is finished after a fixed number of burst endings. No timer supervises the frame. A frame that is cut short is therefore completed by the bursts of whatever comes next. The finished word is held on an output register, and a strobe marks it as new for one cycle.

Top module: `ird_decoder`

## Requirements
- R1: During and right after reset, `code_valid_o` is 0 and `code_o` is all zeros.
- R2: A frame starts only after the carrier has been present without a break for `HDR_US` microsecond ticks. Bursts shorter than that, and their rising edges, have no effect while the block waits for a frame start. They produce no strobe and do not disturb the next word.
- R3: Once a frame has started, every rising edge of `rx_n_i` counts as one burst ending. The end of the start burst is ending 1. Ending 2 carries no data. Endings 3 to 34 each deliver one data bit.
- R4: A data bit is 1 when the carrier-off gap before the burst just ended lasted more than `ONE_US` ticks, and 0 otherwise.
- R5: Bits are collected least significant first. The bit delivered at ending 3 appears in `code_o[0]`, and the bit delivered at ending 34 appears in `code_o[31]`.
- R6: At ending 34, `code_o` is loaded with the word and `code_valid_o` is high for exactly one clock cycle. It is high on the third rising clock edge after `rx_n_i` rises, counting the first edge that samples the high level.
- R7: `code_o` changes only in the cycle where `code_valid_o` is high, and it otherwise holds its value.
- R8: There is no frame timeout. If a frame breaks off early, the following bursts, including the next start burst, are counted as ordinary endings until ending 34 is reached.
- R9: After ending 34 the block goes back to waiting for a frame start. Later short bursts are ignored, and the next qualifying start burst clears the counters.
- R10: `rx_n_i` passes through two synchronising flip-flops before any edge detection or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency given by `CLK_HZ` |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_n_i | input | 1 | Demodulated receiver output, low while carrier is present, asynchronous |
| code_o | output | WORD_W | Last decoded word, first received bit in bit 0 |
| code_valid_o | output | 1 | Single-cycle strobe marking a new `code_o` |

## Verification
A rising input driven between clock edges reaches the synchroniser on the next edge and the edge detector one edge later. The word register and the strobe load on the third edge, so the bench samples `code_o` and `code_valid_o` at the falling clock edge after that third rising edge. It then samples again one cycle later to confirm the strobe has dropped. Every gap and burst is a whole number of microseconds, kept well clear of both thresholds, so that the one-tick uncertainty of the free-running divider cannot change how a bit or a start burst is classified. A reference model driven by the same burst list predicts at which ending a word completes and what it holds, including frames that are cut short.

// File: rtl/ird_pkg.sv
package ird_pkg;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } ird_state_e;

    // burst endings that precede the first data bit
    localparam int LEAD_EDGES = 2;

endpackage

// File: rtl/ird_us_tick.sv
module ird_us_tick #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DIV   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int DIV_W = (DIV < 2) ? 1 : $clog2(DIV);

    generate
        if (DIV == 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);
            logic [DIV_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);

            // R4
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/ird_rx_sync.sv
module ird_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_n_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic meta_q, lvl_q, prev_q;

    // R10: two flops, then one more for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            lvl_q  <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_n_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign rise_o = lvl_q & ~prev_q;
    assign fall_o = ~lvl_q & prev_q;

    // R10
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/ird_decoder.sv
module ird_decoder #(
    parameter int CLK_HZ = 50_000_000,
    parameter int HDR_US = 3500,
    parameter int ONE_US = 1500,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_n_i,
    output logic [WORD_W-1:0] code_o,
    output logic              code_valid_o
);
    import ird_pkg::*;

    localparam int EDGES    = WORD_W + LEAD_EDGES;
    localparam int CAR_W    = $clog2(HDR_US + 1);
    localparam int GAP_SAT  = ONE_US + 1;
    localparam int GAP_W    = $clog2(GAP_SAT + 1);
    localparam int ECNT_W   = $clog2(EDGES + 1);

    localparam logic [CAR_W-1:0]  CAR_TOP   = CAR_W'(HDR_US);
    localparam logic [GAP_W-1:0]  GAP_TOP   = GAP_W'(GAP_SAT);
    localparam logic [ECNT_W-1:0] EDGE_LAST = ECNT_W'(EDGES);
    localparam logic [ECNT_W-1:0] EDGE_DATA = ECNT_W'(LEAD_EDGES + 1);

    typedef struct packed {
        ird_state_e        state;
        logic [CAR_W-1:0]  car_cnt;
        logic [GAP_W-1:0]  gap_cnt;
        logic              gap_long;
        logic [ECNT_W-1:0] edge_cnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] code;
        logic              valid;
    } dec_regs_t;

    dec_regs_t r_d, r_q;

    logic tick, rx_lvl, rx_rise, rx_fall;
    logic carrier;
    logic [ECNT_W-1:0] edge_next;
    logic [WORD_W-1:0] shifted;

    ird_us_tick #(.CLK_HZ(CLK_HZ)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ird_rx_sync i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_n_i (rx_n_i),
        .lvl_o  (rx_lvl),
        .rise_o (rx_rise),
        .fall_o (rx_fall)
    );

    assign carrier   = ~rx_lvl;
    assign edge_next = r_q.edge_cnt + 1'b1;
    assign shifted   = {r_q.gap_long, r_q.shreg[WORD_W-1:1]};

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;

        // carrier-off gap length, saturating just above the 1 threshold
        if (rx_rise) begin
            r_d.gap_cnt = '0;
        end else if (!carrier && tick && r_q.gap_cnt != GAP_TOP) begin
            r_d.gap_cnt = r_q.gap_cnt + 1'b1;
        end
        if (rx_fall) begin
            r_d.gap_long = (r_q.gap_cnt == GAP_TOP);
        end

        unique case (r_q.state)
            ST_HUNT: begin
                if (!carrier) begin
                    r_d.car_cnt = '0;
                end else if (tick && r_q.car_cnt != CAR_TOP) begin
                    r_d.car_cnt = r_q.car_cnt + 1'b1;
                end
                if (r_q.car_cnt == CAR_TOP) begin
                    r_d.state    = ST_FRAME;
                    r_d.car_cnt  = '0;
                    r_d.edge_cnt = '0;
                    r_d.shreg    = '0;
                end
            end
            ST_FRAME: begin
                if (rx_rise) begin
                    r_d.edge_cnt = edge_next;
                    if (edge_next >= EDGE_DATA) begin
                        r_d.shreg = shifted;
                    end
                    if (edge_next == EDGE_LAST) begin
                        r_d.code     = shifted;
                        r_d.valid    = 1'b1;
                        r_d.state    = ST_HUNT;
                        r_d.edge_cnt = '0;
                    end
                end
            end
            default: r_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_HUNT, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o       = r_q.code;
    assign code_valid_o = r_q.valid;

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |=> !code_valid_o);

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid_o |-> $stable(code_o));

    // R9
    back_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> (r_q.state == ST_HUNT) && ($past(r_q.state) == ST_FRAME));

    // R3
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.edge_cnt < EDGE_LAST);

    // R2
    hunt_idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HUNT) |-> (r_q.edge_cnt == '0));

endmodule

// File: tb/test_ird_decoder.sv
module test_ird_decoder;

    localparam int CLK_HZ = 4_000_000;
    localparam int DIV    = 4;
    localparam int HDR_US = 40;
    localparam int ONE_US = 12;
    localparam int W      = 32;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_n  = 1'b1;
    logic [W-1:0] code;
    logic         valid;

    int checks = 0, errors = 0, pulses = 0, exp_pulses = 0;
    bit done = 1'b0;

    bit           m_frame = 1'b0;
    int           m_cnt   = 0;
    logic [W-1:0] m_sh    = '0;
    bit           m_long  = 1'b0;
    logic [W-1:0] last_word = '0;

    always #10 clk = ~clk;

    ird_decoder #(.CLK_HZ(CLK_HZ), .HDR_US(HDR_US), .ONE_US(ONE_US), .WORD_W(W)) i_ird_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_n_i       (rx_n),
        .code_o       (code),
        .code_valid_o (valid)
    );

    always @(negedge clk) if (rst_n && valid) pulses++;

    task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // one carrier burst of on_us, then off_us without carrier; reference model updated at the burst end
    task automatic burst(int on_us, int off_us, string tag);
        bit           exp_done = 1'b0;
        logic [W-1:0] exp_w    = '0;
        rx_n = 1'b0;
        repeat (on_us * DIV) @(negedge clk);
        if (!m_frame) begin
            if (on_us >= HDR_US) begin
                m_frame = 1'b1;
                m_cnt   = 1;
                m_sh    = '0;
            end
        end else begin
            m_cnt++;
            if (m_cnt >= 3) m_sh = {m_long, m_sh[W-1:1]};
            if (m_cnt == W + 2) begin
                exp_done  = 1'b1;
                exp_w     = m_sh;
                m_frame   = 1'b0;
                exp_pulses++;
                last_word = m_sh;
            end
        end
        rx_n = 1'b1;
        for (int i = 0; i < off_us * DIV; i++) begin
            @(negedge clk);
            if (exp_done && i == 2) begin
                check(valid === 1'b1, {tag, " R6 R10 strobe due"}, W'(valid), W'(1));
                check(code === exp_w, {tag, " R3 R4 R5 word"}, code, exp_w);
            end
            if (exp_done && i == 3) begin
                check(valid === 1'b0, {tag, " R6 strobe one cycle"}, W'(valid), W'(0));
            end
        end
        m_long = (off_us > ONE_US);
    endtask

    task automatic data_bit(bit b, string tag);
        int on_us  = 4 + int'($urandom % 5);
        int off_us = b ? 18 + int'($urandom % 9) : 3 + int'($urandom % 6);
        burst(on_us, off_us, tag);
    endtask

    task automatic send_frame(logic [W-1:0] w, string tag);
        burst(60 + int'($urandom % 10), 25, tag);
        for (int i = 0; i < W; i++) data_bit(w[i], tag);
        burst(6, 30, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check(valid === 1'b0, "R1 valid in reset", W'(valid), W'(0));
        check(code === '0, "R1 code in reset", code, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(valid === 1'b0 && code === '0, "R1 after reset", code, '0);

        // directed patterns
        send_frame(32'h0000_0000, "all zeros");
        send_frame(32'hFFFF_FFFF, "all ones");
        send_frame(32'h0000_0001, "R5 lsb");
        send_frame(32'h8000_0000, "R5 msb");
        send_frame(32'hA5C3_0F96, "mixed");

        // R2: short bursts while hunting have no effect
        for (int i = 0; i < 6; i++) burst(20, 8 + 10 * (i % 2), "R2 noise");
        check(pulses == exp_pulses, "R2 no strobe from noise", W'(pulses), W'(exp_pulses));
        check(code === last_word, "R2 R7 word kept", code, last_word);
        send_frame(32'h1234_5678, "R2 after noise");

        // R8: frame cut short, completed by the next frame's bursts
        burst(60, 25, "R8 cut");
        for (int i = 0; i < 10; i++) data_bit(i[0], "R8 cut");
        burst(6, 40, "R8 cut");
        send_frame(32'hDEAD_BEEF, "R8 fill");
        // R9: clean frame after resynchronising
        send_frame(32'h0F0F_3C3C, "R9 recover");

        for (int n = 0; n < 14; n++) send_frame($urandom, "random");

        repeat (20) @(negedge clk);
        check(pulses == exp_pulses, "R6 strobe count", W'(pulses), W'(exp_pulses));
        check(code === last_word, "R7 word held", code, last_word);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
            $finish;
        end
    end

endmodule